// File: doc/BRIEF.md
# NAND Flash Block-Erase Sequencer

This block sits on the host side of an 8-bit NAND flash bus and runs one block erase from start to finish. A one-clock `start` pulse, together with a block number on `blk_addr`, launches the sequence. The block first issues the erase-setup command, then the row address bytes, then the erase-confirm command, each as its own bus write. After that it waits for the device's ready/busy line to return high. It then issues the read-status command and reads the status byte, and reports the result through `done` and `error`. Every bus timing is a count of system clocks set by a parameter. `ROW_CYCLES` picks two or three row address cycles to match the device density.

The row address is the block number shifted left by `PAGE_BITS`. The page-within-block bits therefore go out as zero, and no column byte is sent. The bits of the final address cycle above `LAST_BITS` are forced to zero. While the erase runs, a wait counter holds off sampling of ready/busy for a short settling window, and it ends the operation with an error if the line stays low too long.

The control FSM has eight states. `ST_IDLE` goes to `ST_SETUP_CMD` on start. `ST_SETUP_CMD` goes to `ST_ROW_ADDR` when its bus cycle ends. `ST_ROW_ADDR` repeats once per address byte and then goes to `ST_CONFIRM`. `ST_CONFIRM` goes to `ST_WAIT_RB`. From `ST_WAIT_RB` there are two exits: to `ST_STAT_CMD` once the device is ready (the ready path), or to `ST_DONE` when the wait expires (the timeout path). `ST_STAT_CMD` goes to `ST_STAT_READ`, `ST_STAT_READ` goes to `ST_DONE`, and `ST_DONE` always goes back to `ST_IDLE` one clock later.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset the outputs are idle: `nand_ce_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1, `nand_dq_oe`=0, `nand_dq_o`=0, and `busy`, `done` and `error` are all 0.
- R2: A `start` seen high at a clock edge in the idle state raises `busy`, drives `nand_ce_n` low and clears `error` at that edge. `busy` and low `nand_ce_n` then hold until the `done` clock, where both are released.
- R3: Each bus cycle consists of the following clocks, in order. First comes one gap clock with all strobes inactive. Then come `T_SETUP` clocks with the latch enable (`nand_cle` for commands, `nand_ale` for addresses) and the data (`nand_dq_oe`=1) valid and the strobe high. Then come `T_WE_LOW` clocks with the strobe low. Then come `T_WE_HIGH` clocks with the strobe high and the latch and data still held.
- R4: The bus writes go out in this order: command 0x60 with `nand_cle`, then `ROW_CYCLES` address bytes with `nand_ale`, then command 0xD0 with `nand_cle`.
- R5: Address byte k (k=0 first) is bits [8k+7:8k] of `blk_addr << PAGE_BITS`. In the last byte, every bit at position `LAST_BITS` or above is 0.
- R6: After the confirm cycle, `nand_rb` is ignored for the first `T_WB-1` clocks of the wait. From then on, the first clock on which `nand_rb` is sampled high moves the block to the status command on the next clock.
- R7: The status step writes command 0x70 with `nand_cle` and then makes one read cycle. The read cycle has the same timing as R3, but `nand_re_n` is low in place of `nand_we_n` and `nand_dq_oe`, `nand_cle` and `nand_ale` stay 0. `nand_dq_i` is captured on the last low clock.
- R8: `done` is high for exactly one clock, the clock after the read cycle ends. From then on `error` equals bit 0 of the captured status byte and holds until the next accepted start.
- R9: If `nand_rb` is still sampled low when the wait has lasted `TIMEOUT` clocks, `done` pulses on the next clock with `error`=1, and no status cycle is made.
- R10: A `start` during a running erase or during the `done` clock is ignored. The bus sequence and the results are unchanged.
- R11: `nand_we_n` and `nand_re_n` are never low together, and `nand_cle` and `nand_ale` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase (one clock) |
| blk_addr | input | BLK_W (13) | Block number to erase |
| busy | output | 1 | Erase sequence in progress |
| done | output | 1 | One-clock completion pulse |
| error | output | 1 | Status bit 0 or timeout; held until next start |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data driven to the bus |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Data read from the bus |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
A reference timeline in the bench predicts every output on every clock. The bench targets these corner cases:
- An all-ones block number. A design that fails to mask the final address byte would put stray high bits on it.
- A ready line that never drops, or that drops only briefly. A design that samples too early would skip the busy period and read status one clock too soon.
- A ready line stuck low. This checks that the timeout fires on exactly the right clock and that no status read follows it.
- Start pulses sent mid-erase and in the `done` clock. A design that accepts them would restart the command sequence or change the reported result.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP_CMD,
        ST_ROW_ADDR,
        ST_CONFIRM,
        ST_WAIT_RB,
        ST_STAT_CMD,
        ST_STAT_READ,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        CYC_CMD,
        CYC_ADDR,
        CYC_READ
    } bus_kind_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HOLD
    } phase_t;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
    import nand_erase_pkg::*;
#(
    parameter int T_SETUP   = 2,
    parameter int T_WE_LOW  = 3,
    parameter int T_WE_HIGH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  bus_kind_t  kind,
    input  logic [7:0] wdata,
    input  logic [7:0] dq_i,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_o,
    output logic       dq_oe,
    output logic       fin,
    output logic [7:0] rdata
);

    localparam int TMAX = (T_SETUP > T_WE_LOW) ?
                          ((T_SETUP > T_WE_HIGH) ? T_SETUP : T_WE_HIGH) :
                          ((T_WE_LOW > T_WE_HIGH) ? T_WE_LOW : T_WE_HIGH);
    localparam int CW = $clog2(TMAX + 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    bus_kind_t     kind_q;
    logic [7:0]    data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            kind_q <= CYC_CMD;
            data_q <= '0;
            rdata  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase  <= PH_SETUP;
                        cnt    <= CW'(T_SETUP - 1);
                        kind_q <= kind;
                        data_q <= wdata;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_LOW;
                        cnt   <= CW'(T_WE_LOW - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= CW'(T_WE_HIGH - 1);
                        if (kind_q == CYC_READ) rdata <= dq_i;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    logic active;
    always_comb begin
        active = (phase != PH_IDLE);
        cle    = active && (kind_q == CYC_CMD);
        ale    = active && (kind_q == CYC_ADDR);
        dq_oe  = active && (kind_q != CYC_READ);
        dq_o   = dq_oe ? data_q : 8'h00;
        we_n   = !((phase == PH_LOW) && (kind_q != CYC_READ));
        re_n   = !((phase == PH_LOW) && (kind_q == CYC_READ));
        fin    = (phase == PH_HOLD) && (cnt == '0);
    end

    // R11: the two strobes never overlap
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R3: a write strobe is only ever low while data is being driven
    assert_we_with_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);

    // R3: a latch enable first rises while the write strobe is still high
    assert_latch_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cle || ale) |-> we_n);

endmodule

// File: rtl/nand_row_bytes.sv
module nand_row_bytes #(
    parameter int ROW_CYCLES = 3,
    parameter int LAST_BITS  = 2,
    parameter int PAGE_BITS  = 5,
    localparam int ROW_W     = 8 * (ROW_CYCLES - 1) + LAST_BITS,
    localparam int BLK_W     = ROW_W - PAGE_BITS
) (
    input  logic [BLK_W-1:0]            blk,
    output logic [ROW_CYCLES-1:0][7:0]  bytes
);

    logic [ROW_W-1:0] row;
    assign row = {blk, {PAGE_BITS{1'b0}}};

    for (genvar g = 0; g < ROW_CYCLES; g++) begin : g_byte
        if (g < ROW_CYCLES - 1) begin : g_full
            assign bytes[g] = row[8*g +: 8];
        end else if (LAST_BITS == 8) begin : g_last_full
            assign bytes[g] = row[8*g +: 8];
        end else begin : g_last_part
            assign bytes[g] = {{(8 - LAST_BITS){1'b0}}, row[8*g +: LAST_BITS]};
        end
    end

endmodule

// File: rtl/nand_rb_timer.sv
module nand_rb_timer #(
    parameter int T_WB    = 4,
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic settle_ok,
    output logic expired
);

    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (!run)                       cnt <= '0;
        else if (cnt != CW'(TIMEOUT - 1))    cnt <= cnt + 1'b1;
    end

    always_comb begin
        settle_ok = run && (cnt >= CW'(T_WB - 1));
        expired   = run && (cnt == CW'(TIMEOUT - 1));
    end

    // R9: the wait can only expire after the settling window has elapsed
    assert_expire_after_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> settle_ok);

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int ROW_CYCLES = 3,
    parameter int LAST_BITS  = 2,
    parameter int PAGE_BITS  = 5,
    parameter int T_SETUP    = 2,
    parameter int T_WE_LOW   = 3,
    parameter int T_WE_HIGH  = 2,
    parameter int T_WB       = 4,
    parameter int TIMEOUT    = 1000,
    localparam int BLK_W     = 8 * (ROW_CYCLES - 1) + LAST_BITS - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] blk_addr,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_i,
    input  logic             nand_rb
);

    localparam int AW = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(ROW_CYCLES - 1);

    seq_state_t state, state_n;
    logic       go_q, go_n;
    logic [AW-1:0]   addr_idx;
    logic [BLK_W-1:0] blk_q;
    logic       error_q;

    logic [ROW_CYCLES-1:0][7:0] row_bytes;
    bus_kind_t  cyc_kind;
    logic [7:0] cyc_data;
    logic       cyc_fin;
    logic [7:0] stat_byte;
    logic       tmr_settle, tmr_expired;

    nand_row_bytes #(
        .ROW_CYCLES (ROW_CYCLES),
        .LAST_BITS  (LAST_BITS),
        .PAGE_BITS  (PAGE_BITS)
    ) u_rows (
        .blk   (blk_q),
        .bytes (row_bytes)
    );

    nand_bus_cycle #(
        .T_SETUP   (T_SETUP),
        .T_WE_LOW  (T_WE_LOW),
        .T_WE_HIGH (T_WE_HIGH)
    ) u_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go_q),
        .kind  (cyc_kind),
        .wdata (cyc_data),
        .dq_i  (nand_dq_i),
        .cle   (nand_cle),
        .ale   (nand_ale),
        .we_n  (nand_we_n),
        .re_n  (nand_re_n),
        .dq_o  (nand_dq_o),
        .dq_oe (nand_dq_oe),
        .fin   (cyc_fin),
        .rdata (stat_byte)
    );

    nand_rb_timer #(
        .T_WB    (T_WB),
        .TIMEOUT (TIMEOUT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state == ST_WAIT_RB),
        .settle_ok (tmr_settle),
        .expired   (tmr_expired)
    );

    wire unused_stat_hi = ^stat_byte[7:1];

    // next-state decode
    always_comb begin
        state_n = state;
        go_n    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_SETUP_CMD;
                    go_n    = 1'b1;
                end
            end
            ST_SETUP_CMD: begin
                if (cyc_fin) begin
                    state_n = ST_ROW_ADDR;
                    go_n    = 1'b1;
                end
            end
            ST_ROW_ADDR: begin
                if (cyc_fin) begin
                    go_n = 1'b1;
                    if (addr_idx == LAST_IDX) state_n = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (cyc_fin) state_n = ST_WAIT_RB;
            end
            ST_WAIT_RB: begin
                if (tmr_settle && nand_rb) begin
                    state_n = ST_STAT_CMD;
                    go_n    = 1'b1;
                end else if (tmr_expired) begin
                    state_n = ST_DONE;
                end
            end
            ST_STAT_CMD: begin
                if (cyc_fin) begin
                    state_n = ST_STAT_READ;
                    go_n    = 1'b1;
                end
            end
            ST_STAT_READ: begin
                if (cyc_fin) state_n = ST_DONE;
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            go_q     <= 1'b0;
            addr_idx <= '0;
            blk_q    <= '0;
            error_q  <= 1'b0;
        end else begin
            state <= state_n;
            go_q  <= go_n;
            if (state == ST_IDLE && start) begin
                blk_q    <= blk_addr;
                addr_idx <= '0;
                error_q  <= 1'b0;
            end
            if (state == ST_ROW_ADDR && cyc_fin && addr_idx != LAST_IDX)
                addr_idx <= addr_idx + 1'b1;
            if (state == ST_WAIT_RB && !(tmr_settle && nand_rb) && tmr_expired)
                error_q <= 1'b1;
            if (state == ST_STAT_READ && cyc_fin)
                error_q <= stat_byte[0];
        end
    end

    // outputs and bus-cycle selection
    always_comb begin
        cyc_kind = CYC_CMD;
        cyc_data = 8'h00;
        unique case (state)
            ST_SETUP_CMD: cyc_data = OP_ERASE_SETUP;
            ST_ROW_ADDR: begin
                cyc_kind = CYC_ADDR;
                cyc_data = row_bytes[addr_idx];
            end
            ST_CONFIRM:   cyc_data = OP_ERASE_GO;
            ST_STAT_CMD:  cyc_data = OP_READ_STATUS;
            ST_STAT_READ: cyc_kind = CYC_READ;
            default: ;
        endcase
        busy      = (state != ST_IDLE) && (state != ST_DONE);
        done      = (state == ST_DONE);
        nand_ce_n = !busy;
        error     = error_q;
    end

    // R11: command and address latches are never enabled together
    assert_latch_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R2: busy only rises after a start request
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3: chip enable is low whenever the write strobe is low
    assert_ce_under_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !nand_ce_n);

    // R8: done lasts a single clock
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: high bits of the last address byte are zero while it is latched
    assert_last_addr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW_ADDR && addr_idx == LAST_IDX && !nand_we_n)
            |-> ((nand_dq_o >> LAST_BITS) == 8'h00));

    // R9: a timeout ends the erase with an error on the next clock
    assert_timeout_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RB && tmr_expired && !nand_rb) |=> (done && error));

    // R10: a start in the done clock does not relaunch the sequence
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !busy);

endmodule

// File: tb/nand_erase_seq_test.sv
module nand_erase_seq_test;

    localparam int ROW_CYCLES = 3;
    localparam int LAST_BITS  = 2;
    localparam int PAGE_BITS  = 5;
    localparam int TS         = 2;
    localparam int TL         = 3;
    localparam int TH         = 2;
    localparam int T_WB       = 4;
    localparam int TMO        = 1000;
    localparam int BLK_W      = 8 * (ROW_CYCLES - 1) + LAST_BITS - PAGE_BITS;
    localparam int SLOT       = 1 + TS + TL + TH;
    localparam int NWR        = 2 + ROW_CYCLES;
    localparam int W0         = NWR * SLOT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [BLK_W-1:0] blk_addr = '0;
    logic             busy, done, error;
    logic             nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]       nand_dq_o;
    logic             nand_dq_oe;
    logic [7:0]       nand_dq_i = 8'h00;
    logic             nand_rb = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // scenario timeline
    int  rb_lo, rb_hi, s0, done_obs;
    bit  tmo_run;
    bit  err_final;
    int  blk_cur;
    string tag_override;

    always #5 clk = ~clk;

    nand_erase_seq #(
        .ROW_CYCLES (ROW_CYCLES), .LAST_BITS (LAST_BITS), .PAGE_BITS (PAGE_BITS),
        .T_SETUP (TS), .T_WE_LOW (TL), .T_WE_HIGH (TH),
        .T_WB (T_WB), .TIMEOUT (TMO)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start (start), .blk_addr (blk_addr),
        .busy (busy), .done (done), .error (error),
        .nand_ce_n (nand_ce_n), .nand_cle (nand_cle), .nand_ale (nand_ale),
        .nand_we_n (nand_we_n), .nand_re_n (nand_re_n),
        .nand_dq_o (nand_dq_o), .nand_dq_oe (nand_dq_oe),
        .nand_dq_i (nand_dq_i), .nand_rb (nand_rb)
    );

    function automatic bit rb_at(int n);
        return !(n >= rb_lo && n < rb_hi);
    endfunction

    // R5: address byte k of (block << PAGE_BITS), last byte masked
    function automatic logic [7:0] addr_byte(int k);
        longint row = longint'(blk_cur) << PAGE_BITS;
        int b = int'((row >> (8 * k)) & 255);
        if (k == ROW_CYCLES - 1) b = b & ((1 << LAST_BITS) - 1);
        return 8'(b);
    endfunction

    task automatic check_obs(int n);
        logic [15:0] exp_v, act_v;
        logic e_ce_n = 1, e_cle = 0, e_ale = 0, e_we_n = 1, e_re_n = 1, e_oe = 0;
        logic e_busy = 0, e_done = 0, e_err;
        logic [7:0] e_dq = 8'h00;
        string req;
        int off = 0;
        bit rd = 0;
        logic [7:0] wd = 8'h00;
        int kind = 0; // 0 cmd, 1 addr, 2 read
        e_err = err_final;
        req = "R8";
        if (n < done_obs) begin
            e_busy = 1; e_ce_n = 0; e_err = 0; req = "R2";
            if (n < W0) begin
                int i = n / SLOT;
                off = n % SLOT;
                if (i == 0)            begin wd = 8'h60; req = "R4"; end
                else if (i == NWR - 1) begin wd = 8'hD0; req = "R4"; end
                else begin kind = 1; wd = addr_byte(i - 1); req = "R5"; end
                rd = 1;
            end else if (!tmo_run && n >= s0) begin
                int j = (n - s0) / SLOT;
                off = (n - s0) % SLOT;
                req = "R7";
                if (j == 0) wd = 8'h70; else kind = 2;
                rd = 1;
            end else begin
                req = "R6";
            end
            if (rd && off > 0) begin
                bit low = (off > TS) && (off <= TS + TL);
                if (off <= TS && req != "R7") req = "R3";
                if (kind == 2) begin
                    e_re_n = !low;
                end else begin
                    e_cle  = (kind == 0);
                    e_ale  = (kind == 1);
                    e_oe   = 1;
                    e_dq   = wd;
                    e_we_n = !low;
                end
            end
        end else if (n == done_obs) begin
            e_done = 1;
            req = tmo_run ? "R9" : "R8";
        end
        if (tag_override != "") req = tag_override;
        exp_v = {e_ce_n, e_cle, e_ale, e_we_n, e_re_n, e_oe, e_busy, e_done, e_dq};
        act_v = {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe,
                 busy, done, nand_dq_o};
        n_cmp++;
        if (act_v !== exp_v || error !== e_err) begin
            n_bad++;
            $display("FAIL %s obs %0d: actual bus=%h err=%b expected bus=%h err=%b",
                     req, n, act_v, error, exp_v, e_err);
        end
        // R11: strobes never low together, latches never high together
        if ((!nand_we_n && !nand_re_n) || (nand_cle && nand_ale)) begin
            n_bad++;
            $display("FAIL R11 obs %0d: actual we_n=%b re_n=%b cle=%b ale=%b expected no overlap",
                     n, nand_we_n, nand_re_n, nand_cle, nand_ale);
        end
    endtask

    task automatic run_scen(int blk, int lo_rel, int len, logic [7:0] stat,
                            bit extra_starts, string tag);
        bit found = 0;
        int r = 0;
        blk_cur = blk;
        rb_lo = W0 + lo_rel;
        rb_hi = rb_lo + len;
        tag_override = tag;
        for (int n = W0 + T_WB - 1; n <= W0 + TMO - 1; n++) begin
            if (rb_at(n)) begin r = n; found = 1; break; end
        end
        tmo_run = !found;
        if (found) begin
            s0 = r + 1;
            done_obs = r + 2 * SLOT + 1;
            err_final = stat[0];
        end else begin
            s0 = 0;
            done_obs = W0 + TMO;
            err_final = 1;
        end
        @(negedge clk);
        start = 1;
        blk_addr = BLK_W'(blk);
        nand_dq_i = stat;
        nand_rb = 1;
        for (int n = 0; n <= done_obs + 3; n++) begin
            @(negedge clk);
            check_obs(n);
            nand_rb = rb_at(n);
            // R10: extra start pulses mid-erase and in the done clock
            start = extra_starts && (n == 5 || n == W0 + 2 || n == done_obs);
            if (extra_starts && n == 5) blk_addr = '1;
        end
        start = 0;
        nand_rb = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual run still going expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tag_override = "R1";
        done_obs = -10;
        err_final = 0;
        tmo_run = 0;
        s0 = 0; rb_lo = 0; rb_hi = 0; blk_cur = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_obs(1000000); // R1 during reset
        rst_n = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_obs(1000000); // R1 after reset
        end
        // R4 R5 R6 R7 R8: normal erase, status pass
        run_scen(13'h1ABC, 1, 30, 8'hE0, 0, "");
        // R5 R8: all-ones block, failing status bit 0
        run_scen(13'h1FFF, 0, 10, 8'hC1, 0, "");
        // R6: ready line never drops, early samples ignored
        run_scen(13'h0001, 0, 0, 8'h00, 0, "");
        // R6: brief low pulse inside the settle window
        run_scen(13'h0A55, 0, 2, 8'h02, 0, "");
        // R9: ready line stuck low
        run_scen(13'h0123, 0, 100000, 8'h00, 0, "");
        // R10: start pulses while running and in the done clock
        run_scen(13'h0F0F, 2, 20, 8'h01, 1, "R10");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule